// File: doc/BRIEF.md
# Goto-Repetition Handshake Monitor

This block is a synthesizable runtime checker for a single-bit request/busy/done handshake. A request pulse opens a check. From the next cycle on, the monitor counts the cycles in which busy is high. These busy cycles need not be adjacent. Done must then arrive in the cycle right after a busy cycle whose running count lies inside an accepted range.

Two parameters, `MIN_CNT` and `MAX_CNT`, bound that range. Setting them equal gives the fixed-count form of the check. The monitor tracks one request at a time. It reports each verdict as a one-cycle pass or fail pulse. It flags any request that arrives while a check is still open. It never times out while it waits for busy, so a sequence that has not yet failed stays open.

Top module: `handshake_goto_monitor`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pass_o`, `fail_o`, `active_o` and `overlap_o` are all low.
- R2: When `req_i` is sampled high while the monitor is idle, `active_o` goes high in the next cycle. A busy in that same request cycle is not counted.
- R3: Busy cycles are counted one by one while the monitor is active. Cycles with busy low may fall between them without resetting the count.
- R4: If `done_i` is high in the cycle right after a busy cycle that brought the count to a value from `MIN_CNT` to `MAX_CNT`, then `pass_o` is high for exactly one cycle, in the next cycle. `active_o` drops in that same cycle.
- R5: If `done_i` is low in the cycle right after the busy cycle that brought the count to `MAX_CNT`, then `fail_o` is high for exactly one cycle, in the next cycle, and the monitor returns to idle.
- R6: If `done_i` is low in the cycle right after a busy cycle that brought the count into range but below `MAX_CNT`, the check stays open. A later busy cycle can still qualify, and a late done with no busy just before it is not accepted.
- R7: A `done_i` that arrives while the count is below `MIN_CNT` is ignored: no pass, no fail, and the check stays open.
- R8: A `req_i` sampled high while the monitor is active gives a one-cycle `overlap_o` pulse in the next cycle. It does not restart the count or the check.
- R9: With no busy, an open check stays active with no limit on time.
- R10: `pass_o` and `fail_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request that opens a check |
| busy_i | input | 1 | Busy indication, counted non-consecutively |
| done_i | input | 1 | Completion indication |
| pass_o | output | 1 | One-cycle pulse: the sequence completed |
| fail_o | output | 1 | One-cycle pulse: done missed after the maximum count |
| active_o | output | 1 | A check is open |
| overlap_o | output | 1 | One-cycle pulse: request seen during an open check |

## Verification
The bench builds two copies that share the same inputs. One uses a range of 2 to 4 busy cycles. The other uses an exact count of 3. Applying each trace to both at once shows the same stimulus giving a pass on one and a fail or an ignored done on the other. A late done fails the fixed copy but leaves the range copy open. Consecutive busy bursts reach each copy's maximum at a different cycle. A busy in the request cycle changes the verdict only of the exact-count copy.

// File: rtl/hgm_pkg.sv
package hgm_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_TRACK = 1'b1
  } mon_state_e;

  function automatic int cnt_bits(input int max_val);
    int w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/hgm_busy_tally.sv
module hgm_busy_tally #(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             track_i,
  input  logic             busy_i,
  input  logic             finish_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             window_o
);

  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             win_q, win_d;
  logic             upd_en;

  assign cnt_inc = cnt_q + 1'b1;
  assign upd_en  = start_i | finish_i | track_i;

  // next-state: count busy cycles, open the done window after a qualifying busy
  always_comb begin
    cnt_d = cnt_q;
    win_d = win_q;
    if (start_i || finish_i) begin
      cnt_d = '0;
      win_d = 1'b0;
    end else if (track_i) begin
      if (busy_i) begin
        cnt_d = cnt_inc;
        win_d = (cnt_inc >= MIN_V);
      end else begin
        win_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign window_o = win_q;

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V);

  // R7
  window_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_q |-> (cnt_q >= MIN_V));

  // R3
  busy_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (track_i && !busy_i && !start_i && !finish_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/hgm_ctrl.sv
module hgm_ctrl
  import hgm_pkg::*;
#(
  parameter int MAX_CNT = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             window_i,
  output logic             start_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             clash_o,
  output logic             track_o
);

  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CNT);

  mon_state_e state_q, state_d;
  logic       tracking;

  assign tracking = (state_q == ST_TRACK);
  assign start_o  = (state_q == ST_IDLE) & req_i;
  assign hit_o    = tracking & window_i & done_i;
  assign miss_o   = tracking & window_i & ~done_i & (cnt_i == MAX_V);
  assign clash_o  = tracking & req_i;
  assign track_o  = tracking;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_TRACK;
      ST_TRACK: if (hit_o || miss_o) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clash_o && !hit_o && !miss_o) |=> (state_q == ST_TRACK));

  // R10
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  // R2
  track_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tracking) |-> $past(req_i));

endmodule

// File: rtl/hgm_flags.sv
module hgm_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic miss_i,
  input  logic clash_i,
  output logic pass_o,
  output logic fail_o,
  output logic overlap_o
);

  logic pass_q, fail_q, ovl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      ovl_q  <= 1'b0;
    end else begin
      pass_q <= hit_i;
      fail_q <= miss_i;
      ovl_q  <= clash_i;
    end
  end

  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign overlap_o = ovl_q;

  // R4
  pass_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_q |=> !pass_q);

  // R5
  fail_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |=> !fail_q);

endmodule

// File: rtl/handshake_goto_monitor.sv
module handshake_goto_monitor #(
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic busy_i,
  input  logic done_i,
  output logic pass_o,
  output logic fail_o,
  output logic active_o,
  output logic overlap_o
);

  localparam int CNT_W = hgm_pkg::cnt_bits(MAX_CNT);

  logic [CNT_W-1:0] cnt;
  logic             window, start, hit, miss, clash, track;

  hgm_ctrl #(.MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
    .cnt_i(cnt), .window_i(window), .start_o(start), .hit_o(hit),
    .miss_o(miss), .clash_o(clash), .track_o(track)
  );

  hgm_busy_tally #(.MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT), .CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .start_i(start), .track_i(track),
    .busy_i(busy_i), .finish_i(hit | miss), .cnt_o(cnt), .window_o(window)
  );

  hgm_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .miss_i(miss), .clash_i(clash),
    .pass_o(pass_o), .fail_o(fail_o), .overlap_o(overlap_o)
  );

  assign active_o = track;

  // R10
  pass_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  // R5
  fail_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> ($past(cnt) == CNT_W'(MAX_CNT)));

  // R4
  pass_ends_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> !active_o);

endmodule

// File: tb/handshake_goto_monitor_test.sv
module handshake_goto_monitor_test;

  logic clk = 1'b0;
  logic rst_n;
  logic req, busy, done;
  logic pass_a, fail_a, act_a, ovl_a;
  logic pass_b, fail_b, act_b, ovl_b;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  logic [63:0] pa, fa, aa, oa, pb, fb, ab, ob;

  always #4 clk = ~clk;

  handshake_goto_monitor #(.MIN_CNT(2), .MAX_CNT(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .done_i(done),
    .pass_o(pass_a), .fail_o(fail_a), .active_o(act_a), .overlap_o(ovl_a)
  );

  handshake_goto_monitor #(.MIN_CNT(3), .MAX_CNT(3)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_i(busy), .done_i(done),
    .pass_o(pass_b), .fail_o(fail_b), .active_o(act_b), .overlap_o(ovl_b)
  );

  task automatic check_vec(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp, input int n);
    logic [63:0] mask;
    mask = (n >= 63) ? '1 : ((64'd1 << (n + 1)) - 64'd1);
    vectors++;
    if ((act & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act & mask, exp & mask);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; busy = 1'b0; done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // bit i of each result word is the output seen in cycle i
  task automatic run_trace(input logic [63:0] rq, input logic [63:0] bs,
                           input logic [63:0] dn, input int n);
    pa = '0; fa = '0; aa = '0; oa = '0; pb = '0; fb = '0; ab = '0; ob = '0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      pa[i] = pass_a; fa[i] = fail_a; aa[i] = act_a; oa[i] = ovl_a;
      pb[i] = pass_b; fb[i] = fail_b; ab[i] = act_b; ob[i] = ovl_b;
      req  = (i < n) ? rq[i] : 1'b0;
      busy = (i < n) ? bs[i] : 1'b0;
      done = (i < n) ? dn[i] : 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b1; busy = 1'b1; done = 1'b1;
    @(negedge clk);
    check_vec("R1", "outputs in reset", {60'd0, pass_a, fail_a, act_a, ovl_a}, 64'd0, 4);
    rst_n = 1'b1; req = 1'b0; busy = 1'b0; done = 1'b0;
    @(negedge clk);
    check_vec("R1", "outputs after release", {60'd0, pass_b, fail_b, act_b, ovl_b}, 64'd0, 4);
  endtask

  task automatic t_reference();
    do_reset();
    run_trace(64'h2, 64'h54, 64'h80, 10);
    check_vec("R4", "range pass", pa, 64'h100, 10);
    check_vec("R4", "fixed pass", pb, 64'h100, 10);
    check_vec("R2", "range active", aa, 64'hFC, 10);
    check_vec("R3", "fixed active", ab, 64'hFC, 10);
    check_vec("R10", "range fail", fa, 64'h0, 10);
  endtask

  task automatic t_done_late();
    do_reset();
    run_trace(64'h2, 64'h54, 64'h100, 11);
    check_vec("R6", "range no verdict pass", pa, 64'h0, 11);
    check_vec("R6", "range no verdict fail", fa, 64'h0, 11);
    check_vec("R6", "range still active", aa, 64'hFFC, 11);
    check_vec("R5", "fixed fail", fb, 64'h100, 11);
    check_vec("R5", "fixed active", ab, 64'hFC, 11);
  endtask

  task automatic t_too_few();
    do_reset();
    run_trace(64'h2, 64'h14, 64'h20, 10);
    check_vec("R4", "range pass at min", pa, 64'h40, 10);
    check_vec("R7", "fixed ignores early done pass", pb, 64'h0, 10);
    check_vec("R7", "fixed ignores early done fail", fb, 64'h0, 10);
    check_vec("R7", "fixed still active", ab, 64'h7FC, 10);
  endtask

  task automatic t_burst_max();
    do_reset();
    run_trace(64'h2, 64'h3C, 64'h80, 10);
    check_vec("R5", "range fail at max", fa, 64'h80, 10);
    check_vec("R5", "fixed fail at max", fb, 64'h40, 10);
    check_vec("R10", "range pass absent", pa, 64'h0, 10);
  endtask

  task automatic t_continue();
    do_reset();
    run_trace(64'h2, 64'h94, 64'h100, 11);
    check_vec("R6", "range later busy pass", pa, 64'h200, 11);
    check_vec("R3", "fixed gap busy pass", pb, 64'h200, 11);
  endtask

  task automatic t_overlap();
    do_reset();
    run_trace(64'hA, 64'h54, 64'h80, 10);
    check_vec("R8", "range overlap", oa, 64'h10, 10);
    check_vec("R8", "fixed overlap", ob, 64'h10, 10);
    check_vec("R8", "range pass unchanged", pa, 64'h100, 10);
  endtask

  task automatic t_req_busy();
    do_reset();
    run_trace(64'h2, 64'h2A, 64'h40, 9);
    check_vec("R2", "range pass with two counted", pa, 64'h80, 9);
    check_vec("R2", "fixed req-cycle busy ignored", pb, 64'h0, 9);
  endtask

  task automatic t_no_timeout();
    do_reset();
    run_trace(64'h2, 64'h0, 64'h0, 60);
    check_vec("R9", "range stays active", aa, 64'h1FFF_FFFF_FFFF_FFFC, 60);
    check_vec("R9", "fixed no verdict", pb | fb, 64'h0, 60);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; busy = 1'b0; done = 1'b0;
    t_reset();
    t_reference();
    t_done_late();
    t_too_few();
    t_burst_max();
    t_continue();
    t_overlap();
    t_req_busy();
    t_no_timeout();
    finish_run();
  end

endmodule